// File: doc/BRIEF.md
# TDM Time-Slot Route Assigner

This block sits between a TDM framer and a bank of five internal serial channels. Each frame is a sequence of byte-wide time slots. A run-length route table says which channel owns each slot, and each direction has its own table. An entry in a table covers a run of consecutive slots and names one destination. The block walks the entries in order as the frame progresses. A destination code of zero leaves the slots of that run unrouted.

On the receive side the framer pushes one completed slot byte per beat and flags the first slot of each frame. The block strobes the byte into the owning channel one cycle later. On the transmit side the block owns the slot count of the frame. For each slot it pulls a byte from the owning channel and presents it to the framer. An unrouted slot is filled with idle ones.

The tables are loaded through a plain write port into shadow copies. A shadow copy takes over only at the next frame start of its direction, so no frame is ever routed from a partly updated table.

Top module: `tdm_slot_router`

## Requirements
- R1: A table entry holds a run length minus one in 6 bits (runs of 1 to 64 slots) and a 3-bit destination code. Codes 1 to 5 select channel code-1, which is bit code-1 of the channel vectors. Code 0, and the unassigned codes 6 and 7, leave the slots unrouted.
- R2: Entries are consumed in index order, and each covers the slots that follow those of the entries before it. Entries (2,0),(24,3),(1,0),(5,2) leave slots 0-1 unrouted, give slots 2-25 to channel code 3, leave slot 26 unrouted and give slots 27-31 to channel code 2.
- R3: `rx_ready` is always 1, and every cycle with `rx_valid` high is a slot beat. On the cycle after a beat on a routed slot, `crx_valid` has exactly the owning channel's bit set and `crx_byte` carries the byte. A beat on an unrouted slot gives `crx_valid` all zero on the next cycle.
- R4: A receive beat with `rx_first` high is slot 0. Routing restarts at the first entry, wherever the previous frame stopped.
- R5: On a routed transmit slot, `tx_valid` equals the owning channel's `ctx_valid` bit and `tx_byte` equals that channel's byte. That channel's `ctx_ready` bit equals `tx_ready`, and all other `ctx_ready` bits are 0. The slot advances only on a cycle with `tx_valid` and `tx_ready` both high, so either side can stall it.
- R6: On an unrouted transmit slot, `tx_valid` is 1, `tx_byte` is 8'hFF and `ctx_ready` is all zero.
- R7: Slots past the sum of all run lengths in a table are unrouted in both directions.
- R8: A transmit frame has FRAME_SLOTS slots. `tx_first` is high while slot 0 is presented, and each transmit frame restarts at the first entry.
- R9: When `cfg_we` is high, the entry at `cfg_idx` of the table selected by `cfg_dir` (0 receive, 1 transmit) is written into the shadow copy. With `cfg_last` also high, the table length becomes `cfg_idx`+1. The frame in progress keeps the old routing. The new table is used from the next frame-start beat of that direction, and that beat itself uses it.
- R10: After reset both tables hold one 64-slot unrouted run, `crx_valid` is 0, and the transmit side is at slot 0 presenting idle ones.
- R11: Writing one direction's table never changes the routing of the other direction.
- R12: A 64-slot run routes every slot of a frame shorter than 64 slots to its destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Receive slot byte present |
| rx_ready | output | 1 | Constant 1, receive never stalls |
| rx_first | input | 1 | This receive beat is slot 0 |
| rx_byte | input | BYTE_W | Completed receive slot byte |
| crx_valid | output | 5 | One-hot strobe to the owning channel |
| crx_byte | output | BYTE_W | Byte delivered with the strobe |
| tx_valid | output | 1 | Transmit slot byte available |
| tx_ready | input | 1 | Framer accepts the transmit byte |
| tx_first | output | 1 | Presented transmit slot is slot 0 |
| tx_byte | output | BYTE_W | Transmit slot byte |
| ctx_valid | input | 5 | Per-channel transmit byte available |
| ctx_ready | output | 5 | Per-channel pull, one-hot |
| ctx_byte | input | 5*BYTE_W | Channel bytes, channel k at bits k*BYTE_W upward |
| cfg_we | input | 1 | Table entry write strobe |
| cfg_dir | input | 1 | 0 receive table, 1 transmit table |
| cfg_idx | input | IDX_W | Entry index |
| cfg_run_m1 | input | 6 | Run length minus one |
| cfg_dest | input | 3 | Destination code |
| cfg_last | input | 1 | Entry is the last of the table |

## Verification
The bench builds the block with MAX_ENTRIES=4 and FRAME_SLOTS=40. Four entries are enough for the four-run example table and fill the table to its limit. A 40-slot frame leaves slots 32-39 beyond the example's 32-slot total, which exercises the past-the-end rule. Because 40 is shorter than 64, one maximal run also covers a whole frame. The small sizes keep the frame wrap, the deferred table swap and transmit stalls within a few hundred cycles.

// File: rtl/tsr_pkg.sv
`timescale 1ns/1ps
package tsr_pkg;
  localparam int NUM_CH = 5;
  localparam int DEST_W = 3;
  localparam int RUN_W  = 6;

  typedef struct packed {
    logic [RUN_W-1:0]  run_m1;
    logic [DEST_W-1:0] dest;
  } run_entry_t;

  localparam run_entry_t IDLE_ENTRY = '{run_m1: '1, dest: '0};

  function automatic logic is_chan(input logic [DEST_W-1:0] d);
    return (d != '0) && (d <= DEST_W'(NUM_CH));
  endfunction

  function automatic logic [NUM_CH-1:0] chan_onehot(input logic [DEST_W-1:0] d);
    return is_chan(d) ? (NUM_CH'(1) << (d - DEST_W'(1))) : '0;
  endfunction
endpackage

// File: rtl/tsr_route_table.sv
`timescale 1ns/1ps
module tsr_route_table import tsr_pkg::*; #(
  parameter int MAX_ENTRIES = 64,
  localparam int IDX_W = $clog2(MAX_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  run_entry_t       wentry,
  input  logic             wlast,
  input  logic             apply,
  input  logic [IDX_W-1:0] rd_idx,
  output run_entry_t       rd_entry,
  output logic [IDX_W-1:0] act_last,
  output run_entry_t       head_entry,
  output logic [IDX_W-1:0] head_last
);
  run_entry_t       act [MAX_ENTRIES];
  run_entry_t       shd [MAX_ENTRIES];
  logic [IDX_W-1:0] act_lst_q, shd_lst_q;
  logic             pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MAX_ENTRIES; i++) begin
        act[i] <= IDLE_ENTRY;
        shd[i] <= IDLE_ENTRY;
      end
      act_lst_q <= '0;
      shd_lst_q <= '0;
      pend_q    <= 1'b0;
    end else begin
      if (apply && pend_q) begin
        act       <= shd;
        act_lst_q <= shd_lst_q;
      end
      if (we) begin
        shd[widx] <= wentry;
        if (wlast) shd_lst_q <= widx;
      end
      if (we)         pend_q <= 1'b1;
      else if (apply) pend_q <= 1'b0;
    end
  end

  assign rd_entry   = act[rd_idx];
  assign act_last   = act_lst_q;
  assign head_entry = pend_q ? shd[0] : act[0];
  assign head_last  = pend_q ? shd_lst_q : act_lst_q;

  assert_apply_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && pend_q && !we) |=> !pend_q);
endmodule

// File: rtl/tsr_run_walker.sv
`timescale 1ns/1ps
module tsr_run_walker import tsr_pkg::*; #(
  parameter int IDX_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              advance,
  input  logic              restart,
  input  run_entry_t        cur_entry,
  input  logic [IDX_W-1:0]  cur_last,
  input  run_entry_t        head_entry,
  input  logic [IDX_W-1:0]  head_last,
  output logic [IDX_W-1:0]  ptr_o,
  output logic [DEST_W-1:0] dest_o
);
  logic [IDX_W-1:0] ptr_q, p, p_n;
  logic [RUN_W-1:0] used_q, u, u_n;
  logic             done_q, d, d_n;
  run_entry_t       e;
  logic [IDX_W-1:0] lst;

  always_comb begin
    e   = restart ? head_entry : cur_entry;
    lst = restart ? head_last  : cur_last;
    p   = restart ? '0   : ptr_q;
    u   = restart ? '0   : used_q;
    d   = restart ? 1'b0 : done_q;
    dest_o = (d || !is_chan(e.dest)) ? '0 : e.dest;
    p_n = p;
    u_n = u;
    d_n = d;
    if (!d) begin
      if (u == e.run_m1) begin
        u_n = '0;
        if (p == lst) d_n = 1'b1;
        else          p_n = p + IDX_W'(1);
      end else begin
        u_n = u + RUN_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      used_q <= '0;
      done_q <= 1'b0;
    end else if (advance) begin
      ptr_q  <= p_n;
      used_q <= u_n;
      done_q <= d_n;
    end
  end

  assign ptr_o = ptr_q;

  assert_run_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |-> (used_q <= cur_entry.run_m1));
  assert_ptr_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |-> (ptr_q <= cur_last));
endmodule

// File: rtl/tdm_slot_router.sv
`timescale 1ns/1ps
module tdm_slot_router import tsr_pkg::*; #(
  parameter int MAX_ENTRIES = 64,
  parameter int FRAME_SLOTS = 32,
  parameter int BYTE_W      = 8,
  localparam int IDX_W  = $clog2(MAX_ENTRIES),
  localparam int SLOT_W = $clog2(FRAME_SLOTS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rx_valid,
  output logic                     rx_ready,
  input  logic                     rx_first,
  input  logic [BYTE_W-1:0]        rx_byte,
  output logic [NUM_CH-1:0]        crx_valid,
  output logic [BYTE_W-1:0]        crx_byte,
  output logic                     tx_valid,
  input  logic                     tx_ready,
  output logic                     tx_first,
  output logic [BYTE_W-1:0]        tx_byte,
  input  logic [NUM_CH-1:0]        ctx_valid,
  output logic [NUM_CH-1:0]        ctx_ready,
  input  logic [NUM_CH*BYTE_W-1:0] ctx_byte,
  input  logic                     cfg_we,
  input  logic                     cfg_dir,
  input  logic [IDX_W-1:0]         cfg_idx,
  input  logic [RUN_W-1:0]         cfg_run_m1,
  input  logic [DEST_W-1:0]        cfg_dest,
  input  logic                     cfg_last
);
  localparam int NDIR = 2;   // 0 receive, 1 transmit

  run_entry_t        wentry;
  logic [NDIR-1:0]   dir_we, dir_apply, dir_restart, dir_adv;
  logic [IDX_W-1:0]  dir_ptr  [NDIR];
  run_entry_t        dir_cur  [NDIR];
  logic [IDX_W-1:0]  dir_clst [NDIR];
  run_entry_t        dir_head [NDIR];
  logic [IDX_W-1:0]  dir_hlst [NDIR];
  logic [DEST_W-1:0] dir_dest [NDIR];

  logic [SLOT_W-1:0] slot_q;
  logic              tx_beat;

  assign wentry = '{run_m1: cfg_run_m1, dest: cfg_dest};

  assign dir_restart[0] = rx_first;
  assign dir_adv[0]     = rx_valid;
  assign dir_restart[1] = tx_first;
  assign dir_adv[1]     = tx_beat;

  for (genvar g = 0; g < NDIR; g++) begin : g_dir
    assign dir_we[g]    = cfg_we && (cfg_dir == g[0]);
    assign dir_apply[g] = dir_adv[g] && dir_restart[g];

    tsr_route_table #(.MAX_ENTRIES(MAX_ENTRIES)) u_tbl (
      .clk(clk), .rst_n(rst_n),
      .we(dir_we[g]), .widx(cfg_idx), .wentry(wentry), .wlast(cfg_last),
      .apply(dir_apply[g]),
      .rd_idx(dir_ptr[g]), .rd_entry(dir_cur[g]), .act_last(dir_clst[g]),
      .head_entry(dir_head[g]), .head_last(dir_hlst[g])
    );

    tsr_run_walker #(.IDX_W(IDX_W)) u_walk (
      .clk(clk), .rst_n(rst_n),
      .advance(dir_adv[g]), .restart(dir_restart[g]),
      .cur_entry(dir_cur[g]), .cur_last(dir_clst[g]),
      .head_entry(dir_head[g]), .head_last(dir_hlst[g]),
      .ptr_o(dir_ptr[g]), .dest_o(dir_dest[g])
    );
  end

  // receive steering
  assign rx_ready = 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crx_valid <= '0;
      crx_byte  <= '0;
    end else begin
      crx_valid <= rx_valid ? chan_onehot(dir_dest[0]) : '0;
      if (rx_valid) crx_byte <= rx_byte;
    end
  end

  // transmit pull
  logic [BYTE_W-1:0] ch_b [NUM_CH];
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign ch_b[c] = ctx_byte[c*BYTE_W +: BYTE_W];
  end

  logic              tx_used;
  logic [DEST_W-1:0] tx_sel;

  always_comb begin
    tx_used   = (dir_dest[1] != '0);
    tx_sel    = dir_dest[1] - DEST_W'(1);
    tx_valid  = tx_used ? ctx_valid[tx_sel] : 1'b1;
    tx_byte   = tx_used ? ch_b[tx_sel] : '1;
    ctx_ready = tx_ready ? chan_onehot(dir_dest[1]) : '0;
  end

  assign tx_beat  = tx_valid && tx_ready;
  assign tx_first = (slot_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)       slot_q <= '0;
    else if (tx_beat) slot_q <= (slot_q == SLOT_W'(FRAME_SLOTS-1)) ? '0 : slot_q + SLOT_W'(1);
  end

  assert_strobe_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(crx_valid));
  assert_strobe_after_beat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (crx_valid != '0) |-> $past(rx_valid));
  assert_pull_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ctx_ready));
  assert_slot_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_valid && tx_ready) |=> $stable(slot_q));
endmodule

// File: tb/tdm_slot_router_bench.sv
`timescale 1ns/1ps
module tdm_slot_router_bench;
  import tsr_pkg::*;
  localparam int ME = 4, FS = 40, BW = 8, IW = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, rx_valid, rx_ready, rx_first, tx_valid, tx_ready, tx_first;
  logic [BW-1:0] rx_byte, crx_byte, tx_byte;
  logic [NUM_CH-1:0] crx_valid, ctx_valid, ctx_ready;
  logic [NUM_CH*BW-1:0] ctx_byte;
  logic cfg_we, cfg_dir, cfg_last;
  logic [IW-1:0] cfg_idx;
  logic [RUN_W-1:0] cfg_run_m1;
  logic [DEST_W-1:0] cfg_dest;

  tdm_slot_router #(.MAX_ENTRIES(ME), .FRAME_SLOTS(FS), .BYTE_W(BW)) u_tdm_slot_router (
    .clk(clk), .rst_n(rst_n),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_first(rx_first), .rx_byte(rx_byte),
    .crx_valid(crx_valid), .crx_byte(crx_byte),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_first(tx_first), .tx_byte(tx_byte),
    .ctx_valid(ctx_valid), .ctx_ready(ctx_ready), .ctx_byte(ctx_byte),
    .cfg_we(cfg_we), .cfg_dir(cfg_dir), .cfg_idx(cfg_idx), .cfg_run_m1(cfg_run_m1),
    .cfg_dest(cfg_dest), .cfg_last(cfg_last)
  );

  int n_chk = 0, n_bad = 0;
  int a_run [2][ME], a_dst [2][ME], a_n [2];
  int s_run [2][ME], s_dst [2][ME], s_n [2];
  bit pend [2];
  int rx_slot = 0, tx_slot = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int exp_dest(input int d, input int slot);
    int base = 0;
    for (int e = 0; e < a_n[d]; e++) begin
      if (slot < base + a_run[d][e]) return (a_dst[d][e] >= 1 && a_dst[d][e] <= 5) ? a_dst[d][e] : 0;
      base += a_run[d][e];
    end
    return 0;
  endfunction

  function automatic int oh(input int dd);
    return (dd == 0) ? 0 : (1 << (dd - 1));
  endfunction

  task automatic apply_model(input int d);
    if (pend[d]) begin
      for (int e = 0; e < ME; e++) begin
        a_run[d][e] = s_run[d][e];
        a_dst[d][e] = s_dst[d][e];
      end
      a_n[d] = s_n[d];
      pend[d] = 0;
    end
  endtask

  task automatic write_entry(input int d, input int idx, input int run, input int dst, input bit last);
    @(negedge clk);
    cfg_we = 1'b1; cfg_dir = d[0]; cfg_idx = IW'(idx);
    cfg_run_m1 = RUN_W'(run - 1); cfg_dest = DEST_W'(dst); cfg_last = last;
    @(negedge clk);
    cfg_we = 1'b0; cfg_last = 1'b0;
    s_run[d][idx] = run; s_dst[d][idx] = dst;
    if (last) s_n[d] = idx + 1;
    pend[d] = 1;
  endtask

  // receive n beats; first marks a frame start on the first beat
  task automatic rx_frame(input int n, input bit first, input string tag);
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      int e;
      logic [BW-1:0] b;
      b = BW'(8'h20 + i);
      rx_valid = 1'b1; rx_first = first && (i == 0); rx_byte = b;
      if (first && i == 0) begin rx_slot = 0; apply_model(0); end
      e = exp_dest(0, rx_slot);
      @(posedge clk);
      @(negedge clk);
      rx_valid = 1'b0; rx_first = 1'b0;
      check((first && i == 0) ? {tag, " R4"} : tag,
            {crx_valid, (crx_valid != 0) ? crx_byte : 8'h00},
            {NUM_CH'(oh(e)), (e != 0) ? b : 8'h00});
      rx_slot++;
    end
  endtask

  task automatic tx_frame(input int n, input string tag);
    @(negedge clk);
    ctx_valid = '1;
    for (int i = 0; i < n; i++) begin
      int e;
      tx_ready = 1'b1;
      if (tx_slot == 0) apply_model(1);
      e = exp_dest(1, tx_slot);
      #1;
      check((tx_slot == 0) ? {tag, " R8"} : tag,
            {tx_first, tx_valid, tx_byte, ctx_ready},
            {(tx_slot == 0), 1'b1, (e != 0) ? BW'(8'hC0 + e) : 8'hFF, NUM_CH'(oh(e))});
      @(posedge clk);
      tx_slot = (tx_slot + 1) % FS;
      @(negedge clk);
    end
    tx_ready = 1'b0;
  endtask

  task automatic test_reset();
    check("R10 reset rx", {rx_ready, crx_valid}, {1'b1, 5'b0});
    check("R10 reset tx", {tx_first, tx_valid, tx_byte, ctx_ready}, {1'b1, 1'b1, 8'hFF, 5'b0});
    rx_frame(4, 1'b1, "R10");
  endtask

  task automatic test_example();
    for (int d = 0; d < 2; d++) begin
      write_entry(d, 0, 2, 0, 0);
      write_entry(d, 1, 24, 3, 0);
      write_entry(d, 2, 1, 0, 0);
      write_entry(d, 3, 5, 2, 1);
    end
    rx_frame(3, 1'b0, "R9 rx old table");
    rx_frame(FS, 1'b1, "R2 R3 R7 rx");
    tx_frame(FS, "R2 R5 R6 R7 tx");
    tx_frame(1, "R8 wrap");
  endtask

  task automatic test_rx_restart();
    rx_frame(10, 1'b1, "R4 partial");
    rx_frame(FS, 1'b1, "R4 restart");
  endtask

  task automatic test_backpressure();
    tx_frame(FS - 1, "R8 finish");
    tx_frame(2, "R5 lead");
    @(negedge clk);
    tx_ready = 1'b0; ctx_valid = '1;
    #1 check("R5 framer stall", {tx_valid, tx_byte, ctx_ready}, {1'b1, 8'hC3, 5'b0});
    @(posedge clk); @(negedge clk);
    #1 check("R5 held slot", {tx_first, tx_byte}, {1'b0, 8'hC3});
    ctx_valid[2] = 1'b0; tx_ready = 1'b1;
    #1 check("R5 channel stall", {tx_valid, ctx_ready}, {1'b0, 5'b00100});
    @(posedge clk); @(negedge clk);
    ctx_valid = '1; tx_ready = 1'b0;
    tx_frame(FS - 2, "R5 after stall");
  endtask

  task automatic test_rewrite();
    write_entry(0, 0, 3, 6, 0);
    write_entry(0, 1, 64, 1, 1);
    rx_frame(FS, 1'b1, "R1 R12 rx");
    tx_frame(10, "R11 tx");
    write_entry(1, 0, 40, 4, 1);
    tx_frame(FS - 10, "R9 tx old table");
    tx_frame(FS, "R9 tx new table");
  endtask

  initial begin
    for (int d = 0; d < 2; d++) begin
      for (int e = 0; e < ME; e++) begin
        a_run[d][e] = 64; a_dst[d][e] = 0; s_run[d][e] = 64; s_dst[d][e] = 0;
      end
      a_n[d] = 1; s_n[d] = 1; pend[d] = 0;
    end
    for (int c = 0; c < NUM_CH; c++) ctx_byte[c*BW +: BW] = BW'(8'hC1 + c);
    rst_n = 1'b0; rx_valid = 1'b0; rx_first = 1'b0; rx_byte = '0;
    tx_ready = 1'b0; ctx_valid = '1;
    cfg_we = 1'b0; cfg_dir = 1'b0; cfg_idx = '0; cfg_run_m1 = '0; cfg_dest = '0; cfg_last = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    test_reset();
    test_example();
    test_rx_restart();
    test_backpressure();
    test_rewrite();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule